// File: doc/BRIEF.md
# Interrupt Request Priority Controller

This block gathers interrupt requests from up to fourteen peripheral sources and turns them into a 3-bit processor priority level. Two registers hold the state. The pending register records which sources are asking for service. The enable register holds one gate bit per source plus a master gate. Software changes either register through one write convention: the top data bit chooses between setting and clearing the bits marked with 1.

Each source bit has a fixed priority between 1 and 6. The output shows the highest priority among the sources that are pending and allowed through. The output is registered.

Nothing from the processor side withdraws a request. The level stays up until software clears the pending bit. A handler that leaves its bit set is therefore entered again as soon as the processor mask allows it. Hardware request pulses set pending bits directly, and they win over a software clear in the same cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A write whose data bit 15 is 1 ORs data bits 14:0 into the addressed register. Address 0 selects the pending register (bits 13:0) and address 1 selects the enable register (bits 14:0).
- R2: A write whose data bit 15 is 0 clears every addressed register bit that is 1 in the data. Data 0x7FFF empties the register in one write.
- R3: Source bits map to levels as follows: bits 0, 1 and 2 map to level 1; bit 3 to level 2; bits 4, 5 and 6 to level 3; bits 7 to 10 to level 4; bits 11 and 12 to level 5; bit 13 to level 6.
- R4: A pending bit counts only when its own enable bit and the master enable (enable bit 14) are both 1. For example, writing 0xC014 to address 1 opens the master gate and sources 2 and 4.
- R5: `irq_level` equals the highest level among the counting sources, or 0 when none count. It follows a register change by one clock.
- R6: `irq_level` never takes the value 7.
- R7: `irq_level` holds its value for as long as the registers are unchanged. Only a clear of the pending bit or of an enable bit lowers it.
- R8: A 1 on `hw_req[i]` sets pending bit i at the next clock edge, even if a software clear of that bit happens in the same cycle.
- R9: `rd_data` shows the addressed register without delay. Bit 15 always reads 0, and pending bits 15:14 read 0.
- R10: Writes to addresses 2 and 3 change no state, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | 2 | Register select: 0 pending, 1 enable |
| wr_data | input | 16 | Write data; bit 15 picks set or clear |
| rd_data | output | 16 | Read data of the addressed register |
| hw_req | input | 14 | Per-source hardware request pulses |
| irq_level | output | 3 | Priority level presented to the processor |

## Verification
A wrong bit in the pending or enable register shows up on `irq_level` exactly one clock after it is written, and it shows up on `rd_data` in the same cycle, so a read-back right after each stimulus exposes it. An error in the level mapping only appears when the faulty source is the highest one counting. For that reason the stimulus raises and then removes sources one level at a time, so that each mapping in turn is the maximum. A fault in hold or set-wins behaviour shows as a level that drops without any clear, or a pending bit missing on the read after the colliding write.

// File: rtl/irq_pkg.sv
// Package: shared constants and the source-to-level map.
// Assumes at most 14 sources. Any index above 13 maps to level 0.
package irq_pkg;
    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] level_t;

    // Priority level assigned to source index idx
    function automatic level_t src_level(input int idx);
        if (idx <= 2)       return 3'd1;
        else if (idx == 3)  return 3'd2;
        else if (idx <= 6)  return 3'd3;
        else if (idx <= 10) return 3'd4;
        else if (idx <= 12) return 3'd5;
        else if (idx == 13) return 3'd6;
        else                return 3'd0;
    endfunction
endpackage

// File: rtl/irq_setclr_reg.sv
// Set/clear register: a selected write either ORs the data bits into the
// register or clears the bits marked 1, chosen by the caller's mode flag.
// hw_set bits are applied after the software update, so a set always beats
// a clear. Assumes wr_sel is already qualified by address decode.
module irq_setclr_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_sel,
    input  logic         set_mode,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] sw_next;

    // Software update of the current value
    always_comb begin
        sw_next = q;
        if (wr_sel) begin
            if (set_mode) sw_next = q | wr_bits;
            else          sw_next = q & ~wr_bits;
        end
    end

    // State register; hardware sets are ORed in last
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= sw_next | hw_set;
    end
endmodule

// File: rtl/irq_prio_encoder.sv
// Combinational maximum-level finder over the gated source vector.
// Assumes the gating (own enable and master enable) is done by the caller.
module irq_prio_encoder #(
    parameter int NUM_SRC = 14
) (
    input  logic [NUM_SRC-1:0]  active,
    output irq_pkg::level_t     level
);
    irq_pkg::level_t src_lvl [NUM_SRC];

    // Per-source constant level, masked by that source's active flag
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_lvl[g] = active[g] ? irq_pkg::src_level(g) : 3'd0;
    end

    // Maximum over all masked source levels
    always_comb begin
        level = 3'd0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_lvl[i] > level) level = src_lvl[i];
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top: pending and enable registers with set/clear writes, source gating,
// maximum-level search and a registered level output.
// Assumes one write per cycle; addresses 2 and 3 are unused.
module irq_prio_ctrl #(
    parameter int NUM_SRC = 14,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_SRC-1:0] hw_req,
    output logic [2:0]        irq_level
);
    localparam int MODE_BIT   = DATA_W - 1;
    localparam int MASTER_BIT = NUM_SRC;
    localparam int EN_W       = NUM_SRC + 1;
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);

    logic [NUM_SRC-1:0] req_q;
    logic [EN_W-1:0]    en_q;
    logic [NUM_SRC-1:0] gated;
    irq_pkg::level_t    lvl_next;
    logic               set_mode;

    assign set_mode = wr_data[MODE_BIT];

    irq_setclr_reg #(.W(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_en && (addr == A_PEND)),
        .set_mode (set_mode),
        .wr_bits  (wr_data[NUM_SRC-1:0]),
        .hw_set   (hw_req),
        .q        (req_q)
    );

    irq_setclr_reg #(.W(EN_W)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_en && (addr == A_EN)),
        .set_mode (set_mode),
        .wr_bits  (wr_data[EN_W-1:0]),
        .hw_set   ('0),
        .q        (en_q)
    );

    // A source counts when pending, individually enabled and master enabled
    assign gated = req_q & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[MASTER_BIT]}};

    irq_prio_encoder #(.NUM_SRC(NUM_SRC)) u_enc (
        .active (gated),
        .level  (lvl_next)
    );

    // Output level register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_level <= 3'd0;
        else        irq_level <= lvl_next;
    end

    // Read multiplexer, zero-extended
    always_comb begin
        rd_data = '0;
        if (addr == A_PEND)    rd_data[NUM_SRC-1:0] = req_q;
        else if (addr == A_EN) rd_data[EN_W-1:0]    = en_q;
    end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Checker for irq_prio_ctrl, attached by bind. It observes ports and the
// two state registers and reports timing relations between them.
module irq_prio_ctrl_chk #(
    parameter int NUM_SRC = 14,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [NUM_SRC-1:0] hw_req,
    input logic [DATA_W-1:0]  rd_data,
    input logic [2:0]         irq_level,
    input logic [NUM_SRC-1:0] req_q,
    input logic [NUM_SRC:0]   en_q
);
    // R6: level 7 never appears
    p_no_seven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level != 3'd7);

    // R8: every hardware pulse leaves its pending bit set
    p_hw_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_req != '0) |=> ((req_q & $past(hw_req)) == $past(hw_req)));

    // R4: master gate closed in the previous cycle gives level 0
    p_master_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_q[NUM_SRC]) |-> (irq_level == 3'd0));

    // R5: nothing pending in the previous cycle gives level 0
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_q) == '0) |-> (irq_level == 3'd0));

    // R7: two quiet cycles keep the level unchanged
    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && hw_req == '0) ##1 (!wr_en && hw_req == '0) |=> $stable(irq_level));

    // R9: top read bit is always 0
    p_read_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1] == 1'b0);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .hw_req    (hw_req),
    .rd_data   (rd_data),
    .irq_level (irq_level),
    .req_q     (req_q),
    .en_q      (en_q)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic [13:0] hw_req = 14'd0;
    logic [2:0]  irq_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .hw_req(hw_req),
        .irq_level(irq_level)
    );

    // {addr, data, expected level}
    localparam int NV = 19;
    localparam logic [20:0] VEC [NV] = '{
        {2'd1, 16'hC014, 3'd0},  // R4 master + sources 2,4
        {2'd0, 16'h8004, 3'd1},  // R1 R3 bit2 -> 1
        {2'd0, 16'h8010, 3'd3},  // R3 bit4 -> 3
        {2'd0, 16'h0010, 3'd1},  // R2 clear bit4
        {2'd0, 16'h8008, 3'd1},  // R4 bit3 not enabled
        {2'd1, 16'h8008, 3'd2},  // R3 bit3 -> 2
        {2'd1, 16'h8020, 3'd2},
        {2'd0, 16'h8020, 3'd3},  // R3 bit5 -> 3
        {2'd1, 16'h4000, 3'd0},  // R4 master off
        {2'd1, 16'hC000, 3'd3},
        {2'd0, 16'hA000, 3'd3},  // bit13 not enabled
        {2'd1, 16'hA000, 3'd6},  // R3 bit13 -> 6
        {2'd0, 16'h7FFF, 3'd0},  // R2 clear all
        {2'd1, 16'hBFFF, 3'd0},
        {2'd0, 16'h8800, 3'd5},  // R3 bit11 -> 5
        {2'd0, 16'h8080, 3'd5},  // R5 max
        {2'd0, 16'h0800, 3'd4},  // R3 bit7 -> 4
        {2'd0, 16'h7FFF, 3'd0},
        {2'd2, 16'hFFFF, 3'd0}   // R10 unused address
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access cycle, then wait for the registered level
    task automatic apply(input logic we, input logic [1:0] a, input logic [15:0] d,
                         input logic [13:0] hw);
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; hw_req = hw;
        @(posedge clk); #1;
        wr_en = 1'b0; hw_req = '0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a;
        #1 check(req, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // reset state
        check("R5 reset level", {13'd0, irq_level}, 16'd0);
        read_chk("R9 reset pending", 2'd0, 16'h0000);
        read_chk("R9 reset enable", 2'd1, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VEC[i][20:19], VEC[i][18:3], '0);
            check($sformatf("R5 vector %0d", i), {13'd0, irq_level}, {13'd0, VEC[i][2:0]});
        end

        read_chk("R9 enable readback", 2'd1, 16'h7FFF);
        read_chk("R10 pending untouched", 2'd0, 16'h0000);
        read_chk("R10 unused read", 2'd3, 16'h0000);

        // R8: hardware set collides with software clear
        apply(1'b1, 2'd0, 16'h0004, 14'h0004);
        read_chk("R8 set wins bit", 2'd0, 16'h0004);
        check("R8 set wins level", {13'd0, irq_level}, 16'd1);

        // R7: level holds with no clear
        repeat (20) @(negedge clk);
        check("R7 hold level", {13'd0, irq_level}, 16'd1);

        // R8: hardware pulse alone
        apply(1'b0, 2'd0, 16'h0000, 14'h2000);
        check("R8 hw pulse level", {13'd0, irq_level}, 16'd6);

        // R6/R9: everything pending
        apply(1'b1, 2'd0, 16'hFFFF, '0);
        check("R6 top level", {13'd0, irq_level}, 16'd6);
        read_chk("R9 pending upper bits zero", 2'd0, 16'h3FFF);

        // R2: clear all of both registers
        apply(1'b1, 2'd0, 16'h7FFF, '0);
        check("R2 clear pending level", {13'd0, irq_level}, 16'd0);
        apply(1'b1, 2'd1, 16'h7FFF, '0);
        read_chk("R2 clear enable", 2'd1, 16'h0000);

        // R4: master on, individual off
        apply(1'b1, 2'd1, 16'hC000, '0);
        apply(1'b1, 2'd0, 16'h8004, '0);
        check("R4 individual gate", {13'd0, irq_level}, 16'd0);
        read_chk("R1 set readback", 2'd0, 16'h0004);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule